// File: doc/BRIEF.md
# CPU Bus Address Decoder with Mirroring

This block sits on the 16-bit address bus of an 8-bit processor and decides which physical resource answers each access. It holds a 2 KB work RAM and a program ROM as internal arrays. It also opens an eight-register window for a peripheral that lives outside the block. Several address ranges are larger than the resource behind them, so the decoder folds them. The RAM range repeats every 2 KB. The peripheral window repeats every eight bytes. The ROM window repeats according to a one-bit size setting that can change at run time.

The processor drives an address, a read strobe, a write strobe and write data. The decoder raises one select line for the target that was hit. For the peripheral window it also gives a register index, and the peripheral itself returns its read data on a dedicated input. Read data is registered and appears in the cycle after the read strobe. The ROM is filled through a separate load port before the processor runs. Processor writes can never alter the ROM.

The RAM page from 0x0100 to 0x01FF serves as the processor stack. 16-bit values are kept low byte first. Neither fact needs special logic, because both are plain RAM accesses.

Top module: `addr_map`

## Requirements
- R1: Addresses whose top three bits are 000 (0x0000 to 0x1FFF) hit work RAM at index addr[10:0], so a byte written at one address reads back at the same offset in all four 2 KB copies. A hit raises sel_ram while a strobe is active.
- R2: Addresses whose top three bits are 001 (0x2000 to 0x3FFF) raise sel_io while a strobe is active and drive io_idx with addr[2:0], so the eight registers repeat across the range.
- R3: Addresses with bit 15 set (0x8000 to 0xFFFF) raise sel_rom while a strobe is active. With rom_big = 1 the ROM index is addr[ROM_AW-1:0], so the whole ROM array is reachable.
- R4: With rom_big = 0 the ROM index is addr[ROM_AW-2:0], so two addresses in the ROM window that differ only in bit ROM_AW-1 return the same byte. With ROM_AW = 15 this is the 16 KB case, where 0x8000 and 0xC000 alias. The default ROM_AW = 12 folds every 2 KB.
- R5: Addresses whose top two bits are 01 (0x4000 to 0x7FFF) raise no select, and a read there returns 0x00.
- R6: A processor write that decodes to ROM leaves the ROM contents unchanged.
- R7: rd_data takes its new value at the rising edge where rd_en is sampled high. It holds its value at edges where rd_en is low, and it is 0x00 after reset.
- R8: No select is raised while both strobes are low, and at most one select is raised at any time.
- R9: A read in the peripheral window returns the value on io_rd_data at the edge where the strobe is sampled.
- R10: With rom_ld_en high, a rising edge stores rom_ld_data at ROM index rom_ld_addr. This does not depend on the processor strobes.
- R11: A read and a write to the same RAM address in the same cycle return the byte held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | Processor address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rom_big | input | 1 | ROM size setting: 1 = full array, 0 = half array folded |
| rom_ld_en | input | 1 | ROM load strobe |
| rom_ld_addr | input | 12 | ROM load index |
| rom_ld_data | input | 8 | ROM load data |
| io_rd_data | input | 8 | Read data returned by the peripheral |
| rd_data | output | 8 | Registered read data |
| sel_ram | output | 1 | Work RAM selected |
| sel_io | output | 1 | Peripheral window selected |
| sel_rom | output | 1 | Program ROM selected |
| io_idx | output | 3 | Peripheral register index |

## Verification
The hardest case to reach from the ports is ROM aliasing, because it depends on the size setting and on whether the array halves hold different bytes. The bench therefore fills the ROM through the load port with random data, so the two halves almost surely differ. It then reads address pairs that differ only in the fold bit under both size settings. A write to ROM is only visibly ignored when the same location is read back afterwards, so the bench follows every ROM write with that read. Random traffic across the whole 64 KB space, with both strobes and both size settings, is checked against a byte-level model of both arrays. Directed cases cover the mirror boundaries and a read and write to the same address in one cycle.

// File: rtl/addr_map_pkg.sv
// Package: shared types for the bus address decoder.
// Assumes a 16-bit address split into four regions by its top bits.
package addr_map_pkg;
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RAM  = 2'd1,
        TGT_IO   = 2'd2,
        TGT_ROM  = 2'd3
    } tgt_e;
endpackage

// File: rtl/map_decode.sv
// Module: map_decode
// Purely combinational region decode and index folding.
// It assumes ADDR_W is at least ROM_AW + 1 and that the region is set by
// the top three address bits.
module map_decode
    import addr_map_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int RAM_AW = 11,
    parameter int IO_AW  = 3,
    parameter int ROM_AW = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rom_big,
    output tgt_e              tgt,
    output logic [RAM_AW-1:0] ram_idx,
    output logic [IO_AW-1:0]  io_idx,
    output logic [ROM_AW-1:0] rom_idx
);
    localparam int OFF_W = ADDR_W - 1;
    localparam logic [OFF_W-1:0] MASK_BIG   = {{(OFF_W-ROM_AW){1'b0}}, {ROM_AW{1'b1}}};
    localparam logic [OFF_W-1:0] MASK_SMALL = MASK_BIG >> 1;

    logic [OFF_W-1:0] rom_off;

    // Pick the target region from the top three address bits.
    always_comb begin
        unique case (addr[ADDR_W-1 -: 3])
            3'b000:         tgt = TGT_RAM;
            3'b001:         tgt = TGT_IO;
            3'b010, 3'b011: tgt = TGT_NONE;
            default:        tgt = TGT_ROM;
        endcase
    end

    // Fold the address into each resource's index space.
    always_comb begin
        ram_idx = RAM_AW'(addr);
        io_idx  = IO_AW'(addr);
        rom_off = addr[OFF_W-1:0] & (rom_big ? MASK_BIG : MASK_SMALL);
        rom_idx = ROM_AW'(rom_off);
    end
endmodule

// File: rtl/ram_store.sv
// Module: ram_store
// Work RAM with a synchronous write and an asynchronous read.
// It assumes the caller gates the write with the region decode.
module ram_store #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store one byte on a qualified write.
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    // Present the addressed byte at once.
    assign rdata = mem[idx];
endmodule

// File: rtl/rom_store.sv
// Module: rom_store
// Program ROM array. Only the load port can write it; processor writes
// never reach this module. It assumes loading happens before use.
module rom_store #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_idx,
    input  logic [DW-1:0] ld_data,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Fill the array from the load port.
    always_ff @(posedge clk) begin
        if (ld_en) mem[ld_idx] <= ld_data;
    end

    // Present the addressed byte at once.
    assign rdata = mem[rd_idx];
endmodule

// File: rtl/addr_map.sv
// Module: addr_map (top)
// Decodes a processor address onto work RAM, a peripheral window or
// program ROM, with mirroring, and registers the read data.
// It assumes one access per cycle. Unmapped reads return zero.
module addr_map
    import addr_map_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int RAM_AW = 11,
    parameter int IO_AW  = 3,
    parameter int ROM_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rom_big,
    input  logic              rom_ld_en,
    input  logic [ROM_AW-1:0] rom_ld_addr,
    input  logic [DATA_W-1:0] rom_ld_data,
    input  logic [DATA_W-1:0] io_rd_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              sel_ram,
    output logic              sel_io,
    output logic              sel_rom,
    output logic [IO_AW-1:0]  io_idx
);
    tgt_e              tgt;
    logic [RAM_AW-1:0] ram_idx;
    logic [ROM_AW-1:0] rom_idx;
    logic [DATA_W-1:0] ram_q;
    logic [DATA_W-1:0] rom_q;
    logic [DATA_W-1:0] rd_mux;
    logic              strobe;

    map_decode #(
        .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .IO_AW(IO_AW), .ROM_AW(ROM_AW)
    ) u_dec (
        .addr(addr), .rom_big(rom_big), .tgt(tgt),
        .ram_idx(ram_idx), .io_idx(io_idx), .rom_idx(rom_idx)
    );

    ram_store #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
        .clk(clk), .we(wr_en && tgt == TGT_RAM), .idx(ram_idx),
        .wdata(wr_data), .rdata(ram_q)
    );

    rom_store #(.AW(ROM_AW), .DW(DATA_W)) u_rom (
        .clk(clk), .ld_en(rom_ld_en), .ld_idx(rom_ld_addr),
        .ld_data(rom_ld_data), .rd_idx(rom_idx), .rdata(rom_q)
    );

    assign strobe = rd_en | wr_en;

    // Raise the select for the decoded target while a strobe is active.
    always_comb begin
        sel_ram = strobe && tgt == TGT_RAM;
        sel_io  = strobe && tgt == TGT_IO;
        sel_rom = strobe && tgt == TGT_ROM;
    end

    // Choose the byte that a read would return.
    always_comb begin
        unique case (tgt)
            TGT_RAM: rd_mux = ram_q;
            TGT_IO:  rd_mux = io_rd_data;
            TGT_ROM: rd_mux = rom_q;
            default: rd_mux = '0;
        endcase
    end

    // Register the read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end
endmodule

// File: rtl/addr_map_chk.sv
// Module: addr_map_chk
// Property checker for addr_map, attached with a bind. It observes
// ports only and drives nothing.
module addr_map_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int IO_AW  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] io_rd_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              sel_ram,
    input logic              sel_io,
    input logic              sel_rom,
    input logic [IO_AW-1:0]  io_idx
);
    // R8
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_ram, sel_io, sel_rom}));

    // R8
    sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en || wr_en) |-> !(sel_ram || sel_io || sel_rom));

    // R2
    io_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_io |-> io_idx == addr[IO_AW-1:0]);

    // R5
    hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[ADDR_W-1 -: 2] == 2'b01) |=> rd_data == '0);

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R9
    io_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel_io) |=> rd_data == $past(io_rd_data));
endmodule

bind addr_map addr_map_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_AW(IO_AW)
) u_chk (.*);

// File: tb/addr_map_bench.sv
// Bench for addr_map: a random mix of accesses, plus directed cases, all
// checked against byte-level models of the RAM and ROM.
module addr_map_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ROM_AW = 12;
    localparam int ROM_N = 1 << ROM_AW;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] addr = '0;
    logic        rd_en = 0, wr_en = 0, rom_big = 1, rom_ld_en = 0;
    logic [7:0]  wr_data = '0, rom_ld_data = '0, io_rd_data = '0;
    logic [ROM_AW-1:0] rom_ld_addr = '0;
    logic [7:0]  rd_data;
    logic        sel_ram, sel_io, sel_rom;
    logic [2:0]  io_idx;

    logic [7:0] ram_m [2048];
    logic [7:0] rom_m [ROM_N];
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_map u_addr_map (.*);

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int region(logic [15:0] a);
        if (a[15]) return 3;
        if (a[14]) return 0;
        return a[13] ? 2 : 1;
    endfunction

    function automatic int rom_index(logic [15:0] a, logic big);
        return big ? int'(a[ROM_AW-1:0]) : int'(a[ROM_AW-2:0]);
    endfunction

    function automatic logic [7:0] exp_byte(logic [15:0] a, logic big, logic [7:0] io);
        case (region(a))
            1: return ram_m[a[10:0]];
            2: return io;
            3: return rom_m[rom_index(a, big)];
            default: return 8'h00;
        endcase
    endfunction

    // One access; checks the selects at once and the read data after the edge.
    task automatic access(logic [15:0] a, logic rd, logic wr, logic [7:0] d, string req);
        logic [7:0] exp;
        logic [7:0] io;
        logic [7:0] prev;
        io = 8'($urandom);
        @(negedge clk);
        addr = a; rd_en = rd; wr_en = wr; wr_data = d; io_rd_data = io;
        prev = rd_data;
        exp = rd ? exp_byte(a, rom_big, io) : prev;
        #1;
        check({req, "/R8 sel"}, {sel_ram, sel_io, sel_rom},
              (rd | wr) ? ((region(a) == 1) ? 4 : (region(a) == 2) ? 2 : (region(a) == 3) ? 1 : 0) : 0);
        if (region(a) == 2 && (rd | wr)) check("R2 io_idx", io_idx, a[2:0]);
        if (wr && region(a) == 1) ram_m[a[10:0]] = d;
        @(negedge clk);
        rd_en = 0; wr_en = 0;
        if (rd) check({req, "/R7 rd_data"}, rd_data, exp);
        else    check("R7 hold", rd_data, prev);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < 2048; i++) ram_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        check("R7 reset", rd_data, 0);
        rst_n = 1;

        // R10: fill the ROM with random bytes through the load port.
        for (int i = 0; i < ROM_N; i++) begin
            @(negedge clk);
            rom_ld_en = 1; rom_ld_addr = ROM_AW'(i); rom_ld_data = 8'($urandom);
            rom_m[i] = rom_ld_data;
        end
        @(negedge clk); rom_ld_en = 0;
        access(16'h8000, 1, 0, 0, "R10 load first");
        access(16'h8FFF, 1, 0, 0, "R10 load last");

        // Clear the RAM model's unknowns by writing every RAM byte once.
        for (int i = 0; i < 2048; i++) access(16'(i), 0, 1, 8'($urandom), "R1 init");
        for (int i = 0; i < 2048; i++) ram_m[i] = 8'h00;
        for (int i = 0; i < 2048; i++) access(16'(i), 0, 1, 8'h00, "R1 zero");

        // R1: write through one mirror, read back through all four.
        access(16'h01FF, 0, 1, 8'hA5, "R1 stack top");
        access(16'h09FF, 1, 0, 0, "R1 mirror1");
        access(16'h11FF, 1, 0, 0, "R1 mirror2");
        access(16'h19FF, 1, 0, 0, "R1 mirror3");
        // R11: read and write in the same cycle return the old byte.
        access(16'h0100, 1, 1, 8'h3C, "R11 old data");
        access(16'h0900, 1, 0, 0, "R11 new data");

        // R2, R9: peripheral window mirrors.
        access(16'h2007, 1, 0, 0, "R9 io read");
        access(16'h3FFA, 1, 1, 8'h11, "R2 io top");

        // R5: hole region.
        access(16'h4000, 1, 0, 0, "R5 hole low");
        access(16'h7FFF, 1, 1, 8'hFF, "R5 hole high");

        // R3, R4: ROM folding under both size settings.
        rom_big = 1;
        access(16'h8123, 1, 0, 0, "R3 big low");
        access(16'h8923, 1, 0, 0, "R3 big high");
        rom_big = 0;
        access(16'h8123, 1, 0, 0, "R4 small low");
        access(16'h8923, 1, 0, 0, "R4 small alias");
        access(16'hF923, 1, 0, 0, "R4 small far");

        // R6: a ROM write leaves the byte unchanged.
        rom_big = 1;
        access(16'h8456, 0, 1, ~rom_m[12'h456], "R6 rom write");
        access(16'h8456, 1, 0, 0, "R6 rom readback");
        access(16'hC456, 1, 1, 8'h00, "R6 rom rd+wr");
        access(16'h8456, 1, 0, 0, "R6 rom readback2");

        // Random mix of accesses over the whole space.
        for (int i = 0; i < 1500; i++) begin
            logic [15:0] a;
            int op;
            a = 16'($urandom);
            if (($urandom % 4) == 0) a[15:13] = 3'b000;
            op = $urandom % 4;
            if (($urandom % 16) == 0) rom_big = ~rom_big;
            access(a, op != 1, op != 0, 8'($urandom), "R1-mix R3");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule